// File: doc/BRIEF.md
# Baseboard Interrupt Fan-Out Router

This block takes a bank of 64 level-sensitive interrupt lines coming from the board and delivers them to two kinds of consumer. The first is a group of four independent board-level interrupt controllers. Each of them receives a full copy of the bank, and the numbering is kept, so input line n drives line n of every controller. The second consumer is the interrupt controller on the processor side. It sees only a sparse selection of the low 32 inputs, and each selected input is renumbered through a fixed routing table.

Each input is sampled once per clock. Both output groups are registered, so each one shows what the inputs held at the previous rising edge. Any processor-side line that no table entry targets is tied low. A synchronous active-high reset clears every output. The controllers themselves are not part of this block.

Top module: `baseirq_router`

## Requirements
- R1: Bit n of `board_irq_o[k]` equals bit n of `irq_in` for every controller k in 0..3 and every line n in 0..63.
- R2: Processor-side routes, first group: input 4 drives `cpu_irq_o[1]`, input 5 drives bit 2, input 10 drives bit 6, input 12 drives bit 4 and input 13 drives bit 5.
- R3: Processor-side routes, second group: input 19 drives `cpu_irq_o[0]`, inputs 17 and 18 drive bits 14 and 15, inputs 20 and 21 drive bits 7 and 8, input 28 drives bit 9 and input 29 drives bit 3.
- R4: Low inputs 0–3, 6–9, 11, 14–16, 22–27, 30 and 31 have no effect on `cpu_irq_o`. They reach only the board controllers.
- R5: Inputs 32 to 63 have no effect on `cpu_irq_o`.
- R6: Bits 10 to 13 and 16 to 31 of `cpu_irq_o` are 0 in every cycle.
- R7: Both output groups reflect the inputs sampled at the previous rising clock edge, which is a latency of exactly one cycle. An input change made between two edges does not show on the outputs before the next edge.
- R8: When `rst` is high at a rising edge, every output is 0 after that edge. Reset is synchronous, so the outputs keep their values until that edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | 64 | Level-sensitive interrupt inputs from the board |
| board_irq_o | output | 4 x 64 | Registered copy of the inputs, one 64-bit row per board controller |
| cpu_irq_o | output | 32 | Registered processor-side interrupt lines after routing |

## Verification
The embedded assertions check the following on every cycle:
- each controller row is a one-cycle-delayed copy of the inputs;
- a sample of the table routes follows its source one cycle later;
- the processor-side lines that no entry targets stay low;
- reset clears both output groups.

Some behaviours can only be shown by the bench's scenarios. These are that unrouted low lines and all high lines leave the processor side untouched, that every one of the twelve routes lands on the correct bit, and that a mid-cycle input change or a reset request waits for the next edge. The bench shows these with walking-one, dense and mixed patterns, compared against its own routing model.

// File: rtl/baseirq_pkg.sv
package baseirq_pkg;

    localparam int unsigned BASE_LINES  = 64;
    localparam int unsigned BOARD_CTRLS = 4;
    localparam int unsigned CPU_LINES   = 32;
    localparam int unsigned ROUTE_SPAN  = 32;
    localparam int unsigned SRC_W       = $clog2(ROUTE_SPAN);

    typedef struct packed {
        logic             valid;
        logic [SRC_W-1:0] src;
    } route_t;

    // For a given processor-side line, return the low board line that feeds it.
    function automatic route_t cpu_route(input int unsigned cpu_line);
        route_t r;
        r.valid = 1'b1;
        case (cpu_line)
            0:       r.src = SRC_W'(19);
            1:       r.src = SRC_W'(4);
            2:       r.src = SRC_W'(5);
            3:       r.src = SRC_W'(29);
            4:       r.src = SRC_W'(12);
            5:       r.src = SRC_W'(13);
            6:       r.src = SRC_W'(10);
            7:       r.src = SRC_W'(20);
            8:       r.src = SRC_W'(21);
            9:       r.src = SRC_W'(28);
            14:      r.src = SRC_W'(17);
            15:      r.src = SRC_W'(18);
            default: begin
                r.valid = 1'b0;
                r.src   = '0;
            end
        endcase
        return r;
    endfunction

    // Mask of processor-side lines that carry a route.
    function automatic logic [CPU_LINES-1:0] routed_mask();
        logic [CPU_LINES-1:0] m;
        m = '0;
        for (int unsigned c = 0; c < CPU_LINES; c++) begin
            m[c] = cpu_route(c).valid;
        end
        return m;
    endfunction

endpackage

// File: rtl/baseirq_fanout.sv
module baseirq_fanout
    import baseirq_pkg::*;
#(
    parameter int unsigned NUM_LINES = BASE_LINES,
    parameter int unsigned NUM_CTRL  = BOARD_CTRLS
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [NUM_LINES-1:0]                lines_i,
    output logic [NUM_CTRL-1:0][NUM_LINES-1:0] ctrl_o
);

    // One register bank per controller keeps each output row local to its consumer.
    for (genvar k = 0; k < NUM_CTRL; k++) begin : g_ctrl
        logic [NUM_LINES-1:0] row_q;

        always_ff @(posedge clk) begin
            if (rst) row_q <= '0;
            else     row_q <= lines_i;
        end

        assign ctrl_o[k] = row_q;

        p_fanout_copy_r1: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (ctrl_o[k] == $past(lines_i)))
            else $error("controller row %0d is not a delayed input copy", k);
    end

endmodule

// File: rtl/baseirq_remap.sv
module baseirq_remap
    import baseirq_pkg::*;
#(
    parameter int unsigned SPAN     = ROUTE_SPAN,
    parameter int unsigned OUT_LINES = CPU_LINES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SPAN-1:0]      low_i,
    output logic [OUT_LINES-1:0] cpu_o
);

    for (genvar c = 0; c < OUT_LINES; c++) begin : g_line
        localparam route_t RT = cpu_route(c);
        if (RT.valid) begin : g_routed
            logic line_q;
            always_ff @(posedge clk) begin
                if (rst) line_q <= 1'b0;
                else     line_q <= low_i[RT.src];
            end
            assign cpu_o[c] = line_q;
        end else begin : g_tied
            assign cpu_o[c] = 1'b0;
        end
    end

endmodule

// File: rtl/baseirq_router.sv
module baseirq_router
    import baseirq_pkg::*;
#(
    parameter int unsigned NUM_LINES = BASE_LINES,
    parameter int unsigned NUM_CTRL  = BOARD_CTRLS,
    parameter int unsigned NUM_CPU   = CPU_LINES
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [NUM_LINES-1:0]                irq_in,
    output logic [NUM_CTRL-1:0][NUM_LINES-1:0] board_irq_o,
    output logic [NUM_CPU-1:0]                 cpu_irq_o
);

    localparam logic [NUM_CPU-1:0] USED = routed_mask();

    logic [ROUTE_SPAN-1:0] low_lines;
    assign low_lines = irq_in[ROUTE_SPAN-1:0];

    baseirq_fanout #(
        .NUM_LINES (NUM_LINES),
        .NUM_CTRL  (NUM_CTRL)
    ) u_fanout (
        .clk     (clk),
        .rst     (rst),
        .lines_i (irq_in),
        .ctrl_o  (board_irq_o)
    );

    baseirq_remap #(
        .SPAN      (ROUTE_SPAN),
        .OUT_LINES (NUM_CPU)
    ) u_remap (
        .clk   (clk),
        .rst   (rst),
        .low_i (low_lines),
        .cpu_o (cpu_irq_o)
    );

    // R2 sample route: board line 4 to processor line 1
    p_route_a_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cpu_irq_o[1] == $past(irq_in[4])))
        else $error("route 4->1 broken");

    // R3 sample routes: board line 19 to processor line 0, line 29 to line 3
    p_route_b_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cpu_irq_o[0] == $past(irq_in[19]) && cpu_irq_o[3] == $past(irq_in[29])))
        else $error("route 19->0 or 29->3 broken");

    p_unrouted_low_r6: assert property (@(posedge clk) disable iff (rst)
        (cpu_irq_o & ~USED) == '0)
        else $error("unrouted processor line driven");

    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> (cpu_irq_o == '0 && board_irq_o == '0))
        else $error("outputs not cleared by reset");

endmodule

// File: tb/baseirq_router_test.sv
module baseirq_router_test;

    localparam int CLK_P = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [63:0]       irq_in = '0;
    logic [3:0][63:0]  board_irq_o;
    logic [31:0]       cpu_irq_o;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #(CLK_P/2) clk = ~clk;

    baseirq_router uut (
        .clk         (clk),
        .rst         (rst),
        .irq_in      (irq_in),
        .board_irq_o (board_irq_o),
        .cpu_irq_o   (cpu_irq_o)
    );

    // Independent model of the processor-side routing (R2, R3; all else 0 for R4-R6)
    function automatic logic [31:0] model_cpu(input logic [63:0] v);
        logic [31:0] e = '0;
        e[1]  = v[4];  e[2]  = v[5];  e[6] = v[10];
        e[4]  = v[12]; e[5]  = v[13];
        e[14] = v[17]; e[15] = v[18]; e[0] = v[19];
        e[7]  = v[20]; e[8]  = v[21];
        e[9]  = v[28]; e[3]  = v[29];
        return e;
    endfunction

    task automatic check_cpu(input string req, input logic [31:0] exp);
        tests++;
        if (cpu_irq_o !== exp) begin
            fails++;
            $display("FAIL %s cpu_irq_o actual=%h expected=%h", req, cpu_irq_o, exp);
        end
    endtask

    task automatic check_board(input string req, input logic [63:0] exp);
        for (int k = 0; k < 4; k++) begin
            tests++;
            if (board_irq_o[k] !== exp) begin
                fails++;
                $display("FAIL %s board_irq_o[%0d] actual=%h expected=%h",
                         req, k, board_irq_o[k], exp);
            end
        end
    endtask

    // Drive at a falling edge, let one rising edge capture, sample at the next falling edge.
    task automatic apply(input logic [63:0] v);
        @(negedge clk) irq_in = v;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        check_cpu("R8", 32'h0);
        check_board("R8", 64'h0);
    endtask

    task automatic t_walk_one();
        for (int n = 0; n < 64; n++) begin
            logic [63:0] v = 64'h1 << n;
            apply(v);
            check_board("R1", v);
            if (n >= 32)      check_cpu("R5", 32'h0);
            else              check_cpu("R2_R3_R4", model_cpu(v));
        end
    endtask

    task automatic t_unrouted_low();
        // every low line without a route, all high: processor side stays idle (R4)
        logic [63:0] v = 64'h0;
        for (int n = 0; n < 32; n++) v[n] = 1'b1;
        v[4] = 0; v[5] = 0; v[10] = 0; v[12] = 0; v[13] = 0;
        v[17] = 0; v[18] = 0; v[19] = 0; v[20] = 0; v[21] = 0; v[28] = 0; v[29] = 0;
        apply(v);
        check_cpu("R4", 32'h0);
        check_board("R1", v);
    endtask

    task automatic t_high_only();
        apply(64'hFFFF_FFFF_0000_0000);
        check_cpu("R5", 32'h0);
        check_board("R1", 64'hFFFF_FFFF_0000_0000);
    endtask

    task automatic t_dense();
        logic [63:0] pats [4] = '{64'hFFFF_FFFF_FFFF_FFFF, 64'h5555_5555_5555_5555,
                                  64'hAAAA_AAAA_AAAA_AAAA, 64'h0123_4567_89AB_CDEF};
        for (int i = 0; i < 4; i++) begin
            apply(pats[i]);
            check_board("R1", pats[i]);
            check_cpu("R2", model_cpu(pats[i]));
            tests++;
            if ((cpu_irq_o & 32'hFFFF_3C00) !== 32'h0) begin
                fails++;
                $display("FAIL R6 unrouted bits actual=%h expected=0", cpu_irq_o & 32'hFFFF_3C00);
            end
        end
    endtask

    task automatic t_latency();
        apply(64'h0);
        @(negedge clk) irq_in = 64'h0000_0000_3030_0000; // lines 20,21,28,29
        #1;
        check_cpu("R7", 32'h0);
        check_board("R7", 64'h0);
        @(negedge clk);
        check_cpu("R7", model_cpu(64'h0000_0000_3030_0000));
        check_board("R7", 64'h0000_0000_3030_0000);
    endtask

    task automatic t_sync_reset();
        apply(64'hFFFF_FFFF_FFFF_FFFF);
        @(negedge clk) rst = 1'b1;
        #1;
        check_cpu("R8", model_cpu(64'hFFFF_FFFF_FFFF_FFFF));
        check_board("R8", 64'hFFFF_FFFF_FFFF_FFFF);
        @(negedge clk);
        check_cpu("R8", 32'h0);
        check_board("R8", 64'h0);
        rst = 1'b0;
        @(negedge clk);
        check_cpu("R3", model_cpu(64'hFFFF_FFFF_FFFF_FFFF));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst = 1'b0;
        t_walk_one();
        t_unrouted_low();
        t_high_only();
        t_dense();
        t_latency();
        t_sync_reset();
        finish_run();
    end

endmodule